// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns eight parallel audio samples into four serial stereo data lines. Line k carries one channel pair: channel 2k in the left slot and channel 2k+1 in the right slot. Each frame holds 64 bit periods, so every channel gets a 32-bit slot. A timing generator supplies a strobe on every bit-clock edge, giving 128 strobes per frame. It can also supply a realignment pulse that marks the start of a frame. From these the block produces the word clock, the bit clock and the serial data.

A two-bit format select picks the framing. In right-justified mode the sample ends on the last bit of its slot and the sign fills the bits in front of it. In left-justified mode the sample starts on the first bit and zeros follow it. Gated mode uses left-justified placement and pulses the bit clock only while sample bits are on the line. The fourth select code holds the block in a synchronous reset. Samples are latched at each frame start, so a change on the sample inputs in the middle of a frame cannot split a word across two values. A mute input forces the data lines low and leaves both clocks running.

Top module: `serial_audio_fmt`

## Requirements
- R1: After `rst_n` is released, the edge counter sits at frame start (edge 0) and every holding register is zero, so the first frame sends all-zero data and the bit clock is low.
- R2: While `fmt_sel` is 2'b10, the counter and the holding registers are cleared on every clock and `wclk_o`, `bclk_o` and all `sdata_o` lines are 0. After release, the first strobe moves the counter to edge 1.
- R3: Edge index h (0..127) advances by one on each `edge_tick_i` and wraps from 127 to 0. The bit index is h/2 and the slot position is (h/2) mod 32. Outside gated mode, `bclk_o` is low for even h and high for odd h, so data changes at a falling edge.
- R4: With `fmt_sel` = 2'b00 (right-justified), `wclk_o` is high for h 0..63 (left slot) and low for h 64..127, so it changes together with a falling bit-clock edge.
- R5: With `fmt_sel` = 2'b01 or 2'b11, `wclk_o` is high for h = 127 and for h 0..62, so it changes together with a rising bit-clock edge.
- R6: `samples_i` packs channel c at bits [c*SAMPLE_W +: SAMPLE_W]. Line k sends channel 2k while h < 64 and channel 2k+1 while h >= 64.
- R7: In right-justified mode, slot positions 0..31-SAMPLE_W carry the sample's sign bit. The sample follows MSB first, and its LSB is at slot position 31.
- R8: In left-justified and gated modes, the sample's MSB is at slot position 0 and positions SAMPLE_W..31 are 0.
- R9: In gated mode, `bclk_o` is high only for odd h whose slot position is below SAMPLE_W, and it is low everywhere else.
- R10: While `mute_i` is high, every `sdata_o` line is 0 and `wclk_o` and `bclk_o` are unchanged.
- R11: Samples are latched at each frame start. A change on `samples_i` during a frame has no effect until the next frame.
- R12: An `edge_tick_i` together with `frame_sync_i` sets h to 0 and latches new samples, whatever the counter value was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 2 | Framing select: 00 right-justified, 01 left-justified, 10 synchronous reset, 11 gated bit clock |
| mute_i | input | 1 | Forces the data lines to zero |
| edge_tick_i | input | 1 | One-cycle strobe for each bit-clock edge (128 per frame) |
| frame_sync_i | input | 1 | When high with a strobe, restarts the frame |
| samples_i | input | 8*SAMPLE_W | Eight packed samples, channel 0 in the low bits |
| wclk_o | output | 1 | Word clock, high during the left slot |
| bclk_o | output | 1 | Bit clock |
| sdata_o | output | 4 | Serial data lines, bit k carries channels 2k and 2k+1 |

## Verification
The hardest case to reach from the ports is a sample update that lands in the middle of a frame. It has to leave the current frame intact and appear exactly at the next frame boundary. The bench tracks the edge index itself. Partway through a frame it rewrites every channel and checks all four lines against the latched values for the rest of that frame, then against the new values in the next frame. A realignment pulse part-way through a frame and a format reset held across several strobes are exercised in the same way. A second instance with 16-bit samples shows the sign fill of short words.

// File: rtl/aof_pkg.sv
`timescale 1ns/1ps
package aof_pkg;

  typedef enum logic [1:0] {
    FMT_RJ    = 2'b00,
    FMT_LJ    = 2'b01,
    FMT_RST   = 2'b10,
    FMT_GATED = 2'b11
  } fmt_e;

  localparam int unsigned SLOT_BITS   = 32;
  localparam int unsigned FRAME_EDGES = 4 * SLOT_BITS;
  localparam int unsigned EDGE_W      = $clog2(FRAME_EDGES);

  // True when slot position pos carries a sample bit under LJ placement
  function automatic logic in_data_window(input logic [4:0] pos, input int unsigned width);
    return 32'(pos) < width;
  endfunction

  // Serial bit for slot position pos of a sample (zero-extended to 32 bits)
  function automatic logic slot_bit(input logic [31:0] smp, input int unsigned width,
                                    input logic [4:0] pos, input logic rj);
    int unsigned lead;
    int unsigned p;
    int unsigned idx;
    lead = SLOT_BITS - width;
    p    = 32'(pos);
    if (rj) begin
      if (p < lead) begin
        idx = width - 1;
      end else begin
        idx = width - 1 - (p - lead);
      end
      return smp[idx[4:0]];
    end
    if (p >= width) return 1'b0;
    idx = width - 1 - p;
    return smp[idx[4:0]];
  endfunction

  // Word-clock level for an edge index under a given framing
  function automatic logic word_clk_level(input fmt_e f, input logic [EDGE_W-1:0] h);
    logic [EDGE_W-1:0] ahead;
    ahead = h + 1'b1;
    if (f == FMT_RJ) return ~h[EDGE_W-1];
    return ~ahead[EDGE_W-1];
  endfunction

endpackage

// File: rtl/aof_timer.sv
`timescale 1ns/1ps
module aof_timer
  import aof_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              edge_tick,
  input  logic              frame_sync,
  output logic [EDGE_W-1:0] edge_cnt,
  output logic              frame_load
);

  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(FRAME_EDGES - 1);

  logic wrap_now;
  assign wrap_now   = (edge_cnt == LAST_EDGE) || frame_sync;
  assign frame_load = edge_tick && wrap_now && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
    end else if (soft_rst) begin
      edge_cnt <= '0;
    end else if (edge_tick) begin
      edge_cnt <= wrap_now ? '0 : edge_cnt + 1'b1;
    end
  end

  // R3: a plain strobe moves the counter forward by exactly one edge
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_tick && !frame_sync && !soft_rst && edge_cnt != LAST_EDGE)
      |=> edge_cnt == $past(edge_cnt) + 1'b1);

  // R3: without a strobe the counter holds
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_tick && !soft_rst) |=> $stable(edge_cnt));

endmodule

// File: rtl/aof_clkgen.sv
`timescale 1ns/1ps
module aof_clkgen
  import aof_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  fmt_e              fmt,
  input  logic [EDGE_W-1:0] edge_cnt,
  output logic              wclk,
  output logic              bclk
);

  logic [4:0] slot_pos;
  logic       high_half;
  assign slot_pos  = edge_cnt[5:1];
  assign high_half = edge_cnt[0];

  always_comb begin
    wclk = 1'b0;
    bclk = 1'b0;
    case (fmt)
      FMT_RST: begin
        wclk = 1'b0;
        bclk = 1'b0;
      end
      FMT_GATED: begin
        wclk = word_clk_level(fmt, edge_cnt);
        bclk = high_half && in_data_window(slot_pos, SAMPLE_W);
      end
      default: begin
        wclk = word_clk_level(fmt, edge_cnt);
        bclk = high_half;
      end
    endcase
  end

endmodule

// File: rtl/aof_lane.sv
`timescale 1ns/1ps
module aof_lane
  import aof_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] samp_l,
  input  logic [SAMPLE_W-1:0] samp_r,
  input  logic [EDGE_W-1:0]   edge_cnt,
  input  logic                rj,
  input  logic                mute,
  output logic                sd
);

  logic [SAMPLE_W-1:0] hold_l;
  logic [SAMPLE_W-1:0] hold_r;
  logic [SAMPLE_W-1:0] cur;
  logic                right_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (soft_rst) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (load) begin
      hold_l <= samp_l;
      hold_r <= samp_r;
    end
  end

  assign right_slot = edge_cnt[EDGE_W-1];
  assign cur        = right_slot ? hold_r : hold_l;

  always_comb begin
    if (soft_rst || mute) begin
      sd = 1'b0;
    end else begin
      sd = slot_bit(32'(cur), SAMPLE_W, edge_cnt[5:1], rj);
    end
  end

  // R11: a frame-start load takes the presented samples
  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !soft_rst) |=> (hold_l == $past(samp_l) && hold_r == $past(samp_r)));

  // R11: between frame starts the held samples do not move
  assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !soft_rst) |=> ($stable(hold_l) && $stable(hold_r)));

endmodule

// File: rtl/serial_audio_fmt.sv
`timescale 1ns/1ps
module serial_audio_fmt
  import aof_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       fmt_sel,
  input  logic                             mute_i,
  input  logic                             edge_tick_i,
  input  logic                             frame_sync_i,
  input  logic [2*NUM_LINES*SAMPLE_W-1:0]  samples_i,
  output logic                             wclk_o,
  output logic                             bclk_o,
  output logic [NUM_LINES-1:0]             sdata_o
);

  fmt_e              fmt;
  logic              soft_rst;
  logic              rj_mode;
  logic [EDGE_W-1:0] edge_cnt;
  logic              frame_load;

  assign fmt      = fmt_e'(fmt_sel);
  assign soft_rst = (fmt == FMT_RST);
  assign rj_mode  = (fmt == FMT_RJ);

  aof_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .edge_tick  (edge_tick_i),
    .frame_sync (frame_sync_i),
    .edge_cnt   (edge_cnt),
    .frame_load (frame_load)
  );

  aof_clkgen #(.SAMPLE_W(SAMPLE_W)) u_clkgen (
    .fmt      (fmt),
    .edge_cnt (edge_cnt),
    .wclk     (wclk_o),
    .bclk     (bclk_o)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    aof_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .load     (frame_load),
      .samp_l   (samples_i[(2*k)*SAMPLE_W +: SAMPLE_W]),
      .samp_r   (samples_i[(2*k+1)*SAMPLE_W +: SAMPLE_W]),
      .edge_cnt (edge_cnt),
      .rj       (rj_mode),
      .mute     (mute_i),
      .sd       (sdata_o[k])
    );
  end

  // R2: a format reset leaves the counter at frame start
  assert_softrst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> edge_cnt == '0);

  // R4: in right-justified framing the word clock only moves while the bit clock is low
  assert_rj_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rj_mode && $past(fmt_sel) == 2'b00 && wclk_o != $past(wclk_o)) |-> !bclk_o);

  // R9: gated bit clock stays low outside the sample bits of a slot
  assert_gate_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_GATED && !in_data_window(edge_cnt[5:1], SAMPLE_W)) |-> !bclk_o);

  // R10: muted lines are low
  assert_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mute_i |-> sdata_o == '0);

endmodule

// File: tb/serial_audio_fmt_tb.sv
`timescale 1ns/1ps
module serial_audio_fmt_tb;

  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b10;
  logic        mute_i = 1'b0;
  logic        edge_tick_i = 1'b0;
  logic        frame_sync_i = 1'b0;
  logic [23:0] smp [NCH];
  logic [NCH*24-1:0] samples24;
  logic [NCH*16-1:0] samples16;
  logic        wclk_a, bclk_a, wclk_b, bclk_b;
  logic [3:0]  sd_a, sd_b;

  int checks = 0;
  int fails  = 0;
  int h_m = 0;
  logic [23:0] hm [NCH];
  string tag = "R1";

  always #10 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      samples24[c*24 +: 24] = smp[c];
      samples16[c*16 +: 16] = smp[c][15:0];
    end
  end

  serial_audio_fmt #(.SAMPLE_W(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .mute_i(mute_i),
    .edge_tick_i(edge_tick_i), .frame_sync_i(frame_sync_i), .samples_i(samples24),
    .wclk_o(wclk_a), .bclk_o(bclk_a), .sdata_o(sd_a));

  serial_audio_fmt #(.SAMPLE_W(16)) u_dut_w16 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .mute_i(mute_i),
    .edge_tick_i(edge_tick_i), .frame_sync_i(frame_sync_i), .samples_i(samples16),
    .wclk_o(wclk_b), .bclk_o(bclk_b), .sdata_o(sd_b));

  // Vector table: format, mute, seed
  localparam int NV = 6;
  localparam logic [1:0]  V_FMT  [NV] = '{2'b00, 2'b01, 2'b11, 2'b00, 2'b01, 2'b11};
  localparam logic        V_MUTE [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] V_SEED [NV] = '{32'h00A5_3C96, 32'h0081_F00D, 32'h00FE_1234,
                                          32'h0077_8899, 32'h00C3_0F0F, 32'h0080_8001};

  function automatic string req_for(input logic [1:0] f, input logic m);
    if (m) return "R10";
    if (f == 2'b00) return "R4/R6/R7";
    if (f == 2'b01) return "R5/R6/R8";
    return "R9/R5/R8";
  endfunction

  function automatic logic e_wclk(input logic [1:0] f, input int h);
    if (f == 2'b10) return 1'b0;
    if (f == 2'b00) return h < 64;
    return (h == 127) || (h < 63);
  endfunction

  function automatic logic e_bclk(input logic [1:0] f, input int h, input int w);
    if (f == 2'b10) return 1'b0;
    if (f == 2'b11) return (h % 2 == 1) && (((h / 2) % 32) < w);
    return h % 2 == 1;
  endfunction

  function automatic logic e_sd(input logic [1:0] f, input logic m, input logic [23:0] s,
                                input int h, input int w);
    logic [31:0] slot;
    logic [31:0] raw;
    int pos;
    if (f == 2'b10 || m) return 1'b0;
    raw = (w == 16) ? {16'b0, s[15:0]} : {8'b0, s};
    pos = (h / 2) % 32;
    if (f == 2'b00) begin
      slot = raw[w-1] ? (raw | (32'hFFFF_FFFF << w)) : raw;
    end else begin
      slot = raw << (32 - w);
    end
    return slot[31 - pos];
  endfunction

  function automatic logic [5:0] expect_vec(input int w);
    logic [5:0] v;
    v[5] = e_wclk(fmt_sel, h_m);
    v[4] = e_bclk(fmt_sel, h_m, w);
    for (int k = 0; k < 4; k++) begin
      v[k] = e_sd(fmt_sel, mute_i, (h_m < 64) ? hm[2*k] : hm[2*k+1], h_m, w);
    end
    return v;
  endfunction

  task automatic compare();
    logic [5:0] ea, eb, ga, gb;
    ea = expect_vec(24);
    eb = expect_vec(16);
    ga = {wclk_a, bclk_a, sd_a};
    gb = {wclk_b, bclk_b, sd_b};
    checks += 2;
    if (ga !== ea) begin
      fails++;
      $display("FAIL %s w24 h=%0d actual=%b expected=%b", tag, h_m, ga, ea);
    end
    if (gb !== eb) begin
      fails++;
      $display("FAIL %s w16 h=%0d actual=%b expected=%b", tag, h_m, gb, eb);
    end
  endtask

  task automatic model_reset();
    h_m = 0;
    for (int c = 0; c < NCH; c++) hm[c] = '0;
  endtask

  // Drive at negedge, let one rising edge pass, update model, check at next negedge
  task automatic step(input logic tick, input logic sync);
    edge_tick_i  = tick;
    frame_sync_i = sync;
    @(posedge clk);
    if (fmt_sel == 2'b10) begin
      model_reset();
    end else if (tick) begin
      if (sync || h_m == 127) begin
        h_m = 0;
        for (int c = 0; c < NCH; c++) hm[c] = smp[c];
      end else begin
        h_m++;
      end
    end
    @(negedge clk);
    edge_tick_i  = 1'b0;
    frame_sync_i = 1'b0;
    compare();
  endtask

  task automatic fill(input logic [31:0] seed);
    for (int c = 0; c < NCH; c++) begin
      smp[c] = 24'(seed * (c + 3) + {c[7:0], 16'h5A00} + (c[0] ? 32'h0080_0000 : 32'h0));
    end
  endtask

  task automatic run_edges(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    fill(32'h0);
    model_reset();
    fmt_sel = 2'b01;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state before any strobe
    tag = "R1";
    compare();
    step(1'b0, 1'b0);
    // R1: first frame after reset sends zeros even with samples present
    fill(32'h0012_3456);
    run_edges(20);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      tag = "R2";
      fmt_sel = 2'b10;
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      fmt_sel = V_FMT[v];
      mute_i  = V_MUTE[v];
      fill(V_SEED[v]);
      tag = req_for(V_FMT[v], V_MUTE[v]);
      run_edges(256);
    end
    mute_i = 1'b0;

    // R2: format reset held across strobes mid-frame, then release
    fmt_sel = 2'b00;
    fill(32'h0055_AA11);
    tag = "R3";
    run_edges(150);
    tag = "R2";
    fmt_sel = 2'b10;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    fmt_sel = 2'b00;
    run_edges(140);

    // R11: rewrite samples mid-frame; held values must persist to frame end
    tag = "R11";
    fmt_sel = 2'b01;
    run_edges(200 - h_m);
    fill(32'h00F1_E2D3);
    run_edges(200);

    // R12: realignment pulse part-way through a frame
    tag = "R12";
    fmt_sel = 2'b00;
    run_edges(40);
    fill(32'h0039_4A5B);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    run_edges(130);

    // R3: idle clocks between strobes must not move anything
    tag = "R3";
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
    run_edges(10);

    finish_run();
  end

endmodule